// File: doc/BRIEF.md
# Cascaded Latched Interrupt Combiner

This block collapses seventeen level-sensitive serial interrupt lines and fifteen event lines into a single upstream interrupt. It does so through two stages of sticky status latches. The first stage is the host-controller stage. Every high level on a source line sets a status bit, and only software clears that bit. The stage raises a pending signal when its global enable bit is set and at least one status bit is unmasked. That pending signal drives one bit of the raw input register of the second stage, the bus-master stage. The second stage folds its masked input into its own sticky status register. The upstream line is high whenever that status is nonzero.

Software reaches both stages over a 32-bit word register port. `reg_sel` selects the stage window, and `reg_addr` gives the byte offset inside that window. Reads are registered: data requested in one cycle appears on `reg_rdata` after the next clock edge and holds until the next read. Every change is evaluated from the next-state values. A source level, a register write, the first-stage pending signal, the second-stage input, the second-stage status and the upstream line all move together at the clock edge that samples the cause.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset the firmware read-size register (window 0, offset 0x28) reads 0x02000000. Every other register reads zero, and `upstream_irq` is low.
- R2: A high level on `serirq_lvl[n]` sets first-stage status bit 31-n (window 0, offset 0x38) at the sampling edge. A low level never clears that bit.
- R3: A high level on `evt_lvl[k]` sets first-stage status bit k (k = 0..14). For example, bit 10 is the bus reset event.
- R4: A write to first-stage status clears each bit written as 1. If a source for a bit is still high in the same cycle, that bit stays set.
- R5: The first-stage pending signal is control bit 31 (window 0, offset 0x30) AND a nonzero (status AND mask, offset 0x34). It appears as bit 11 (0x800) of the second-stage input register (window 1, offset 0x5C). Writes to that input register are ignored.
- R6: Second-stage status (window 1, offset 0x50) becomes status OR (input AND mask, offset 0x54). It stays set until written with ones. If it is cleared while the masked input is still active, it is set again at once.
- R7: `upstream_irq` is high exactly when second-stage status is nonzero. It updates at the same edge. The polarity register (window 1, offset 0x58) has no effect on it.
- R8: The storage registers read back the last value written. These are segment select (0x24), read size (0x28), control, both masks, routing 0 and 1 (window 1, 0x08 and 0x0C) and polarity. The error address register (window 0, offset 0x40) is read-only and reads zero.
- R9: A read of an unmapped offset in either window returns 0xFFFFFFFF. A write to one changes nothing.
- R10: The read data for a request with `reg_rd_en` high appears after the next rising clock edge. It reflects the register values before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | Window select: 0 first stage, 1 second stage |
| reg_addr | input | 8 | Byte offset inside the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| serirq_lvl | input | 17 | Serial interrupt levels, line n maps to status bit 31-n |
| evt_lvl | input | 15 | Event levels, line k maps to status bit k |
| upstream_irq | output | 1 | Combined registered interrupt |

## Verification
The bench first goes after stickiness. It pulses sources for one cycle and then clears the first stage while the second stage must hold. A design that derived status from current levels would lose the pending interrupt. The bench also clears a bit whose source is still high, in both stages. A design that let the clear win would drop a live interrupt for one cycle, and the per-clock comparison of `upstream_irq` would catch that. Further checks cover the global enable gating, the ignored write to the input register, the inert polarity register, the all-ones unmapped read, and the bit reversal of serial line numbers. A wrong mapping shows up as status bit n instead of bit 31-n.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  // first-stage window byte offsets
  localparam logic [7:0] OFS_HC_SEG  = 8'h24;
  localparam logic [7:0] OFS_HC_RDSZ = 8'h28;
  localparam logic [7:0] OFS_HC_CTRL = 8'h30;
  localparam logic [7:0] OFS_HC_MASK = 8'h34;
  localparam logic [7:0] OFS_HC_STAT = 8'h38;
  localparam logic [7:0] OFS_HC_ERRA = 8'h40;
  // second-stage window byte offsets
  localparam logic [7:0] OFS_BM_RT0  = 8'h08;
  localparam logic [7:0] OFS_BM_RT1  = 8'h0C;
  localparam logic [7:0] OFS_BM_STAT = 8'h50;
  localparam logic [7:0] OFS_BM_MASK = 8'h54;
  localparam logic [7:0] OFS_BM_POL  = 8'h58;
  localparam logic [7:0] OFS_BM_IN   = 8'h5C;
  // reset value of the read-size register: 4-byte reads
  localparam logic [31:0] RDSZ_RESET = 32'h0200_0000;
endpackage

// File: rtl/irqagg_hc_stage.sv
module irqagg_hc_stage #(
  parameter int DATA_W     = 32,
  parameter int NUM_SERIRQ = 17,
  parameter int EN_BIT     = 31,
  parameter logic [DATA_W-1:0] RDSZ_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_seg,
  input  logic              wr_rdsz,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SERIRQ-1:0]        serirq,
  input  logic [DATA_W-NUM_SERIRQ-1:0] evt,
  output logic [DATA_W-1:0] seg_q,
  output logic [DATA_W-1:0] rdsz_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              pend_n
);
  localparam int EVT_W = DATA_W - NUM_SERIRQ;

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] ctrl_n, mask_n, stat_n, clr_vec;

  // serial line n lands on bit DATA_W-1-n; events fill the low bits
  for (genvar n = 0; n < NUM_SERIRQ; n++) begin : g_ser
    assign set_vec[DATA_W-1-n] = serirq[n];
  end
  assign set_vec[EVT_W-1:0] = evt;

  always_comb begin
    ctrl_n  = wr_ctrl ? wdata : ctrl_q;
    mask_n  = wr_mask ? wdata : mask_q;
    clr_vec = wr_stat ? wdata : '0;
    stat_n  = (stat_q & ~clr_vec) | set_vec;   // set wins over clear
    pend_n  = ctrl_n[EN_BIT] && ((stat_n & mask_n) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      rdsz_q <= RDSZ_RST;
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_seg)  seg_q  <= wdata;
      if (wr_rdsz) rdsz_q <= wdata;
      ctrl_q <= ctrl_n;
      mask_q <= mask_n;
      stat_q <= stat_n;
    end
  end
endmodule

// File: rtl/irqagg_bm_stage.sv
module irqagg_bm_stage #(
  parameter int DATA_W = 32,
  parameter int HC_BIT = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_rt0,
  input  logic              wr_rt1,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic              wr_pol,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hc_pend_n,
  output logic [DATA_W-1:0] rt0_q,
  output logic [DATA_W-1:0] rt1_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] pol_q,
  output logic [DATA_W-1:0] in_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] in_n, mask_n, stat_n, clr_vec;

  always_comb begin
    in_n         = '0;
    in_n[HC_BIT] = hc_pend_n;
    mask_n       = wr_mask ? wdata : mask_q;
    clr_vec      = wr_stat ? wdata : '0;
    stat_n       = (stat_q & ~clr_vec) | (in_n & mask_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rt0_q  <= '0;
      rt1_q  <= '0;
      pol_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
      in_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_rt0) rt0_q <= wdata;
      if (wr_rt1) rt1_q <= wdata;
      if (wr_pol) pol_q <= wdata;
      mask_q <= mask_n;
      stat_q <= stat_n;
      in_q   <= in_n;
      irq_q  <= (stat_n != '0);
    end
  end
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NUM_SERIRQ = 17,
  parameter int EN_BIT     = 31,
  parameter int HC_BIT     = 11
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr_en,
  input  logic                         reg_rd_en,
  input  logic                         reg_sel,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic [NUM_SERIRQ-1:0]        serirq_lvl,
  input  logic [DATA_W-NUM_SERIRQ-1:0] evt_lvl,
  output logic                         upstream_irq
);
  import irqagg_pkg::*;

  logic hc_win, bm_win;
  logic [DATA_W-1:0] hc_seg_q, hc_rdsz_q, hc_ctrl_q, hc_mask_q, hc_stat_q;
  logic [DATA_W-1:0] bm_rt0_q, bm_rt1_q, bm_stat_q, bm_mask_q, bm_pol_q, bm_in_q;
  logic hc_pend_n;
  logic [DATA_W-1:0] rd_val;

  assign hc_win = reg_wr_en && !reg_sel;
  assign bm_win = reg_wr_en &&  reg_sel;

  irqagg_hc_stage #(
    .DATA_W(DATA_W), .NUM_SERIRQ(NUM_SERIRQ), .EN_BIT(EN_BIT),
    .RDSZ_RST(DATA_W'(RDSZ_RESET))
  ) u_hc (
    .clk     (clk),
    .rst     (rst),
    .wr_seg  (hc_win && reg_addr == ADDR_W'(OFS_HC_SEG)),
    .wr_rdsz (hc_win && reg_addr == ADDR_W'(OFS_HC_RDSZ)),
    .wr_ctrl (hc_win && reg_addr == ADDR_W'(OFS_HC_CTRL)),
    .wr_mask (hc_win && reg_addr == ADDR_W'(OFS_HC_MASK)),
    .wr_stat (hc_win && reg_addr == ADDR_W'(OFS_HC_STAT)),
    .wdata   (reg_wdata),
    .serirq  (serirq_lvl),
    .evt     (evt_lvl),
    .seg_q   (hc_seg_q),
    .rdsz_q  (hc_rdsz_q),
    .ctrl_q  (hc_ctrl_q),
    .mask_q  (hc_mask_q),
    .stat_q  (hc_stat_q),
    .pend_n  (hc_pend_n)
  );

  irqagg_bm_stage #(.DATA_W(DATA_W), .HC_BIT(HC_BIT)) u_bm (
    .clk       (clk),
    .rst       (rst),
    .wr_rt0    (bm_win && reg_addr == ADDR_W'(OFS_BM_RT0)),
    .wr_rt1    (bm_win && reg_addr == ADDR_W'(OFS_BM_RT1)),
    .wr_stat   (bm_win && reg_addr == ADDR_W'(OFS_BM_STAT)),
    .wr_mask   (bm_win && reg_addr == ADDR_W'(OFS_BM_MASK)),
    .wr_pol    (bm_win && reg_addr == ADDR_W'(OFS_BM_POL)),
    .wdata     (reg_wdata),
    .hc_pend_n (hc_pend_n),
    .rt0_q     (bm_rt0_q),
    .rt1_q     (bm_rt1_q),
    .stat_q    (bm_stat_q),
    .mask_q    (bm_mask_q),
    .pol_q     (bm_pol_q),
    .in_q      (bm_in_q),
    .irq_q     (upstream_irq)
  );

  // read mux; unmapped offsets return all ones
  always_comb begin
    rd_val = '1;
    if (!reg_sel) begin
      case (reg_addr)
        ADDR_W'(OFS_HC_SEG):  rd_val = hc_seg_q;
        ADDR_W'(OFS_HC_RDSZ): rd_val = hc_rdsz_q;
        ADDR_W'(OFS_HC_CTRL): rd_val = hc_ctrl_q;
        ADDR_W'(OFS_HC_MASK): rd_val = hc_mask_q;
        ADDR_W'(OFS_HC_STAT): rd_val = hc_stat_q;
        ADDR_W'(OFS_HC_ERRA): rd_val = '0;
        default:              rd_val = '1;
      endcase
    end else begin
      case (reg_addr)
        ADDR_W'(OFS_BM_RT0):  rd_val = bm_rt0_q;
        ADDR_W'(OFS_BM_RT1):  rd_val = bm_rt1_q;
        ADDR_W'(OFS_BM_STAT): rd_val = bm_stat_q;
        ADDR_W'(OFS_BM_MASK): rd_val = bm_mask_q;
        ADDR_W'(OFS_BM_POL):  rd_val = bm_pol_q;
        ADDR_W'(OFS_BM_IN):   rd_val = bm_in_q;
        default:              rd_val = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NUM_SERIRQ = 17,
  parameter int EN_BIT     = 31,
  parameter int HC_BIT     = 11
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr_en,
  input logic                  reg_rd_en,
  input logic                  reg_sel,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic [NUM_SERIRQ-1:0] serirq_lvl,
  input logic [DATA_W-1:0]     hc_ctrl_q,
  input logic [DATA_W-1:0]     hc_stat_q,
  input logic [DATA_W-1:0]     bm_in_q,
  input logic [DATA_W-1:0]     bm_stat_q,
  input logic                  upstream_irq
);
  import irqagg_pkg::*;

  AST_SERIRQ0_LATCH: assert property (@(posedge clk) disable iff (rst)
    serirq_lvl[0] |=> hc_stat_q[DATA_W-1]); // R2

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    !hc_ctrl_q[EN_BIT] |-> !bm_in_q[HC_BIT]); // R5

  AST_BM_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_sel && reg_addr == ADDR_W'(OFS_BM_STAT))
      |=> ((bm_stat_q & $past(bm_stat_q)) == $past(bm_stat_q))); // R6

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (bm_stat_q == '0) |-> !upstream_irq); // R7

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !reg_sel && reg_addr == '0) |=> (reg_rdata == '1)); // R9
endmodule

bind irq_cascade_agg irqagg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SERIRQ(NUM_SERIRQ),
  .EN_BIT(EN_BIT), .HC_BIT(HC_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr_en    (reg_wr_en),
  .reg_rd_en    (reg_rd_en),
  .reg_sel      (reg_sel),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .serirq_lvl   (serirq_lvl),
  .hc_ctrl_q    (hc_ctrl_q),
  .hc_stat_q    (hc_stat_q),
  .bm_in_q      (bm_in_q),
  .bm_stat_q    (bm_stat_q),
  .upstream_irq (upstream_irq)
);

// File: tb/tb_irq_cascade_agg.sv
module tb_irq_cascade_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [16:0] ser = '0;
  logic [14:0] evt = '0;
  logic        irq;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_cascade_agg dut (
    .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_rd_en(rd), .reg_sel(sel),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .serirq_lvl(ser), .evt_lvl(evt), .upstream_irq(irq)
  );

  // behavioural reference: named registers in an associative store
  logic [31:0] m_reg [string];
  logic [31:0] m_rdata;
  bit          m_irq, m_rvalid;

  function automatic string reg_name(bit s, logic [7:0] a);
    case ({s, a})
      {1'b0, 8'h24}: return "seg";   {1'b0, 8'h28}: return "rdsz";
      {1'b0, 8'h30}: return "ctrl";  {1'b0, 8'h34}: return "hmask";
      {1'b0, 8'h38}: return "hstat"; {1'b0, 8'h40}: return "erra";
      {1'b1, 8'h08}: return "rt0";   {1'b1, 8'h0C}: return "rt1";
      {1'b1, 8'h50}: return "bstat"; {1'b1, 8'h54}: return "bmask";
      {1'b1, 8'h58}: return "pol";   {1'b1, 8'h5C}: return "bin";
      default: return "";
    endcase
  endfunction

  task automatic model_reset();
    foreach (m_reg[k]) m_reg[k] = 32'h0;
    m_reg["seg"] = 0; m_reg["rdsz"] = 32'h0200_0000; m_reg["ctrl"] = 0;
    m_reg["hmask"] = 0; m_reg["hstat"] = 0; m_reg["erra"] = 0;
    m_reg["rt0"] = 0; m_reg["rt1"] = 0; m_reg["bstat"] = 0;
    m_reg["bmask"] = 0; m_reg["pol"] = 0; m_reg["bin"] = 0;
    m_irq = 0; m_rdata = 0; m_rvalid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) model_reset();
    else begin
      string n;
      logic [31:0] lat;
      bit pend;
      n = reg_name(sel, addr);
      m_rvalid = rd;
      if (rd) m_rdata = (n == "") ? 32'hFFFF_FFFF : m_reg[n];
      lat = {17'h0, evt};
      for (int i = 0; i < 17; i++) if (ser[i]) lat[31-i] = 1'b1;
      if (wr) begin
        if (n == "hstat")      m_reg["hstat"] = m_reg["hstat"] & ~wdata;
        else if (n == "bstat") m_reg["bstat"] = m_reg["bstat"] & ~wdata;
        else if (n != "" && n != "bin" && n != "erra") m_reg[n] = wdata;
      end
      m_reg["hstat"] = m_reg["hstat"] | lat;
      pend = m_reg["ctrl"][31] && ((m_reg["hstat"] & m_reg["hmask"]) != 0);
      m_reg["bin"] = pend ? 32'h800 : 32'h0;
      m_reg["bstat"] = m_reg["bstat"] | (m_reg["bin"] & m_reg["bmask"]);
      m_irq = (m_reg["bstat"] != 0);
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R7 upstream_irq actual %0b expected %0b at cycle %0d", irq, m_irq, cycles);
      end
      if (m_rvalid) begin
        vectors++;
        if (rdata !== m_rdata) begin
          errors++;
          $display("FAIL R10 model readback actual %08h expected %08h", rdata, m_rdata);
        end
      end
    end
  end

  task automatic wr_reg(bit s, logic [7:0] a, logic [31:0] d);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(bit s, logic [7:0] a, logic [31:0] exp, string tag);
    sel = s; addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    vectors++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s win%0d @%02h actual %08h expected %08h", tag, s, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(bit exp, string tag);
    vectors++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s upstream_irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic pulse_ser(int n);
    ser[n] = 1'b1; @(negedge clk); ser[n] = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd_chk(0, 8'h28, 32'h0200_0000, "R1");
    rd_chk(0, 8'h30, 32'h0, "R1");
    rd_chk(1, 8'h50, 32'h0, "R1");
    irq_chk(0, "R1");
    // R8 storage and read-only
    wr_reg(0, 8'h24, 32'h1234_5678); rd_chk(0, 8'h24, 32'h1234_5678, "R8");
    wr_reg(0, 8'h40, 32'h0000_DEAD); rd_chk(0, 8'h40, 32'h0, "R8");
    wr_reg(1, 8'h08, 32'hA5A5_0001); rd_chk(1, 8'h08, 32'hA5A5_0001, "R8");
    wr_reg(1, 8'h0C, 32'h0000_00FF); rd_chk(1, 8'h0C, 32'h0000_00FF, "R8");
    // R9 unmapped
    rd_chk(0, 8'h00, 32'hFFFF_FFFF, "R9");
    wr_reg(1, 8'h60, 32'h0); rd_chk(1, 8'h60, 32'hFFFF_FFFF, "R9");
    // R2 serial lines, reversed bit order
    pulse_ser(0);  rd_chk(0, 8'h38, 32'h8000_0000, "R2");
    pulse_ser(16); rd_chk(0, 8'h38, 32'h8000_8000, "R2");
    // R3 event bit 10
    evt[10] = 1'b1; @(negedge clk); evt[10] = 1'b0; @(negedge clk);
    rd_chk(0, 8'h38, 32'h8000_8400, "R3");
    // R4 clear, and set-wins
    wr_reg(0, 8'h38, 32'h8000_0000); rd_chk(0, 8'h38, 32'h0000_8400, "R4");
    ser[5] = 1'b1; @(negedge clk);
    wr_reg(0, 8'h38, 32'h0400_0000);
    rd_chk(0, 8'h38, 32'h0400_8400, "R4");
    ser[5] = 1'b0; @(negedge clk);
    // R5 enable gating, input write ignored
    wr_reg(0, 8'h34, 32'h0000_8000);
    rd_chk(1, 8'h5C, 32'h0, "R5");
    wr_reg(0, 8'h30, 32'h8000_0000);
    rd_chk(1, 8'h5C, 32'h0000_0800, "R5");
    wr_reg(1, 8'h5C, 32'h0);
    rd_chk(1, 8'h5C, 32'h0000_0800, "R5");
    rd_chk(1, 8'h50, 32'h0, "R6");
    irq_chk(0, "R6");
    // R6/R7 sticky second stage, inert polarity
    wr_reg(1, 8'h54, 32'h0000_0800);
    irq_chk(1, "R7");
    rd_chk(1, 8'h50, 32'h0000_0800, "R6");
    wr_reg(0, 8'h38, 32'hFFFF_FFFF);
    rd_chk(1, 8'h5C, 32'h0, "R5");
    rd_chk(1, 8'h50, 32'h0000_0800, "R6");
    wr_reg(1, 8'h58, 32'hFFFF_FFFF);
    irq_chk(1, "R7");
    rd_chk(1, 8'h58, 32'hFFFF_FFFF, "R8");
    wr_reg(1, 8'h50, 32'h0000_0800);
    irq_chk(0, "R7");
    rd_chk(1, 8'h50, 32'h0, "R6");
    // R6 re-set while input still active
    wr_reg(0, 8'h34, 32'h1000_8000);
    pulse_ser(3);
    irq_chk(1, "R6");
    wr_reg(1, 8'h50, 32'h0000_0800);
    rd_chk(1, 8'h50, 32'h0000_0800, "R6");
    wr_reg(0, 8'h30, 32'h0);
    rd_chk(1, 8'h5C, 32'h0, "R5");
    irq_chk(1, "R6");
    wr_reg(1, 8'h50, 32'h0000_0800);
    irq_chk(0, "R6");
    rd_chk(0, 8'h38, 32'h1000_0000, "R2");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired, actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule